// File: doc/BRIEF.md
# Instruction Access Exception Checker

This block decides, for one instruction at the point of issue, which access exception that instruction raises, if it raises one. Its inputs are the instruction's attribute flags (floating-point, media, media-trap, floating-register access, non-excepting form, conditional form, privileged), a flag saying the issue group breaks a packing rule, five processor status enables, and a select between the full-featured and the reduced core variant. It returns one exception code. When that code is a floating-point trap, it also returns a trap-type subcode.

The checks form a fixed chain, and the first check that matches owns the result. A matching check blocks every later check, even when it produces no exception itself. The non-excepting and conditional checks give a "not implemented" outcome, and the packing check gives an illegal-instruction outcome. Both are redirected by instruction type on the full-featured variant. The result can be registered behind a valid strobe, which is the default, or passed through combinationally.

Top module: `insn_access_exc_check`

## Requirements
- R1: While reset is asserted and after it, until the first issue, `res_vld` is 0, `res_code` is 0 (none) and `res_sub` is 0.
- R2: With REGISTER_OUT=1, `res_vld` equals `issue_vld` of the previous cycle. When `res_vld` is 0, `res_code` is 0 and `res_sub` is 0, whatever the other inputs are.
- R3: A packing violation gives code 1 (illegal instruction). On the full variant (`full_variant`=1), a floating-point or media instruction instead gives code 2 (floating-point trap) with subcode 4 (sequence error).
- R4: A non-excepting instruction while `st_nonexc_en`=0, or a conditional instruction while `st_cond_en`=0, is not implemented. On the full variant, a floating-point instruction gives code 2 with subcode 3 (unimplemented operation). On the full variant, a media instruction that is not floating-point gives code 3 (media status update only, no interrupt). Every other case gives code 1.
- R5: When `st_fp_en`=0 and no earlier check matched, the result is code 4 (floating-point disabled) for a floating-point instruction, or for a floating-register access while `st_media_en`=0. Otherwise the result is code 0.
- R6: When `st_fp_en`=1, `st_media_en`=0 and no earlier check matched, a media or media-trap instruction gives code 5 (media disabled). Otherwise the result is code 0.
- R7: When no earlier check matched, a privileged instruction with `st_super`=0 gives code 6. With `st_super`=1 the result is code 0.
- R8: The checks are evaluated in this order: packing, non-excepting, conditional, floating-point enable, media enable, privilege. The first check that matches decides the result, even when that result is code 0.
- R9: On the reduced variant (`full_variant`=0), code 2 and code 3 never occur.
- R10: `res_sub` is 0 whenever `res_code` is not 2.
- R11: An issued instruction that matches no check gives code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_vld | input | 1 | An instruction is being checked this cycle |
| full_variant | input | 1 | 1 = full-featured core, 0 = reduced core |
| vliw_viol | input | 1 | The issue group breaks a packing constraint |
| attr_float | input | 1 | Floating-point instruction |
| attr_media | input | 1 | Media instruction |
| attr_mtrap | input | 1 | Media-trap instruction |
| attr_fr_access | input | 1 | Instruction touches a floating register |
| attr_nonexc | input | 1 | Non-excepting instruction form |
| attr_cond | input | 1 | Conditional instruction form |
| attr_priv | input | 1 | Privileged instruction |
| st_nonexc_en | input | 1 | Non-excepting forms enabled |
| st_cond_en | input | 1 | Conditional forms enabled |
| st_fp_en | input | 1 | Floating-point unit enabled |
| st_media_en | input | 1 | Media unit enabled |
| st_super | input | 1 | Supervisor mode |
| res_vld | output | 1 | Result valid |
| res_code | output | 3 | Exception code (0 to 6) |
| res_sub | output | SUB_W | Trap-type subcode for code 2 |

## Verification
The assertions assume that the attribute and status inputs are stable across the cycle in which `issue_vld` is sampled. They compare each result with the inputs that the checker captured at that edge. They also assume that `rst_n` is held long enough for the captured copies to clear.

The bench changes every input only at the falling edge and holds it through the next rising edge. It keeps `issue_vld` low during reset, so the captured state and the result register leave reset together.

// File: rtl/iax_pkg.sv
`timescale 1ns/1ps
package iax_pkg;

   typedef enum logic [2:0] {
      EXC_NONE       = 3'd0,
      EXC_ILLEGAL    = 3'd1,
      EXC_FP_TRAP    = 3'd2,
      EXC_MEDIA_STAT = 3'd3,
      EXC_FP_OFF     = 3'd4,
      EXC_MP_OFF     = 3'd5,
      EXC_PRIV       = 3'd6
   } exc_code_e;

   localparam int unsigned TT_W = 3;
   localparam logic [TT_W-1:0] TT_NONE   = 3'd0;
   localparam logic [TT_W-1:0] TT_UNIMPL = 3'd3;
   localparam logic [TT_W-1:0] TT_SEQ    = 3'd4;

   // check order: lower index wins
   localparam int unsigned N_CHECKS   = 6;
   localparam int unsigned CHK_PACK   = 0;
   localparam int unsigned CHK_NONEXC = 1;
   localparam int unsigned CHK_COND   = 2;
   localparam int unsigned CHK_FPEN   = 3;
   localparam int unsigned CHK_MEDEN  = 4;
   localparam int unsigned CHK_PRIV   = 5;

   typedef struct packed {
      logic flt;
      logic med;
      logic mtrap;
      logic fra;
      logic nonexc;
      logic cond;
      logic priv;
   } insn_attr_t;

   typedef struct packed {
      logic nonexc_en;
      logic cond_en;
      logic fp_en;
      logic media_en;
      logic sup;
   } core_stat_t;

endpackage

// File: rtl/iax_hit_detect.sv
`timescale 1ns/1ps
module iax_hit_detect
   import iax_pkg::*;
(
   input  logic                pack_viol,
   input  insn_attr_t          attr,
   input  core_stat_t          stat,
   output logic [N_CHECKS-1:0] hit
);

   always_comb begin
      hit             = '0;
      hit[CHK_PACK]   = pack_viol;
      hit[CHK_NONEXC] = attr.nonexc & ~stat.nonexc_en;
      hit[CHK_COND]   = attr.cond & ~stat.cond_en;
      hit[CHK_FPEN]   = ~stat.fp_en;
      hit[CHK_MEDEN]  = ~stat.media_en;
      hit[CHK_PRIV]   = attr.priv & ~stat.sup;
   end

endmodule

// File: rtl/iax_first_pick.sv
`timescale 1ns/1ps
module iax_first_pick #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] hit,
   output logic [N-1:0] sel
);

   if (N < 1) begin : g_bad_n
      $error("iax_first_pick: N must be at least 1");
   end

   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign sel[i]       = hit[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | hit[i];
   end

endmodule

// File: rtl/iax_outcome.sv
`timescale 1ns/1ps
module iax_outcome
   import iax_pkg::*;
(
   input  logic [N_CHECKS-1:0] sel,
   input  insn_attr_t          attr,
   input  core_stat_t          stat,
   input  logic                full_var,
   output exc_code_e           code,
   output logic [TT_W-1:0]     tt
);

   always_comb begin
      code = EXC_NONE;
      tt   = TT_NONE;
      if (sel[CHK_PACK]) begin
         if (full_var && (attr.flt || attr.med)) begin
            code = EXC_FP_TRAP;
            tt   = TT_SEQ;
         end else begin
            code = EXC_ILLEGAL;
         end
      end else if (sel[CHK_NONEXC] || sel[CHK_COND]) begin
         if (full_var && attr.flt) begin
            code = EXC_FP_TRAP;
            tt   = TT_UNIMPL;
         end else if (full_var && attr.med) begin
            code = EXC_MEDIA_STAT;
         end else begin
            code = EXC_ILLEGAL;
         end
      end else if (sel[CHK_FPEN]) begin
         if (attr.flt || (attr.fra && !stat.media_en))
            code = EXC_FP_OFF;
      end else if (sel[CHK_MEDEN]) begin
         if (attr.med || attr.mtrap)
            code = EXC_MP_OFF;
      end else if (sel[CHK_PRIV]) begin
         code = EXC_PRIV;
      end
   end

endmodule

// File: rtl/iax_out_stage.sv
`timescale 1ns/1ps
module iax_out_stage
   import iax_pkg::*;
#(
   parameter bit          REGISTER_OUT = 1'b1,
   parameter int unsigned SUB_W        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_in,
   input  exc_code_e        code_in,
   input  logic [TT_W-1:0]  tt_in,
   output logic             vld_out,
   output exc_code_e        code_out,
   output logic [SUB_W-1:0] sub_out
);

   exc_code_e        code_g;
   logic [SUB_W-1:0] sub_g;

   assign code_g = vld_in ? code_in : EXC_NONE;
   assign sub_g  = vld_in ? SUB_W'(tt_in) : '0;

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_out  <= 1'b0;
            code_out <= EXC_NONE;
            sub_out  <= '0;
         end else begin
            vld_out  <= vld_in;
            code_out <= code_g;
            sub_out  <= sub_g;
         end
      end
   end else begin : g_comb
      assign vld_out  = vld_in;
      assign code_out = code_g;
      assign sub_out  = sub_g;
   end

endmodule

// File: rtl/insn_access_exc_check.sv
`timescale 1ns/1ps
module insn_access_exc_check
   import iax_pkg::*;
#(
   parameter bit          REGISTER_OUT = 1'b1,
   parameter int unsigned SUB_W        = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_vld,
   input  logic             full_variant,
   input  logic             vliw_viol,
   input  logic             attr_float,
   input  logic             attr_media,
   input  logic             attr_mtrap,
   input  logic             attr_fr_access,
   input  logic             attr_nonexc,
   input  logic             attr_cond,
   input  logic             attr_priv,
   input  logic             st_nonexc_en,
   input  logic             st_cond_en,
   input  logic             st_fp_en,
   input  logic             st_media_en,
   input  logic             st_super,
   output logic             res_vld,
   output logic [2:0]       res_code,
   output logic [SUB_W-1:0] res_sub
);

   if (SUB_W < TT_W) begin : g_bad_sub_w
      $error("insn_access_exc_check: SUB_W must hold the trap-type field");
   end

   insn_attr_t          attr;
   core_stat_t          stat;
   logic [N_CHECKS-1:0] hit;
   logic [N_CHECKS-1:0] sel;
   exc_code_e           code_c;
   logic [TT_W-1:0]     tt_c;
   exc_code_e           code_q;

   assign attr = '{flt: attr_float, med: attr_media, mtrap: attr_mtrap,
                   fra: attr_fr_access, nonexc: attr_nonexc,
                   cond: attr_cond, priv: attr_priv};
   assign stat = '{nonexc_en: st_nonexc_en, cond_en: st_cond_en,
                   fp_en: st_fp_en, media_en: st_media_en, sup: st_super};

   iax_hit_detect u_hit (
      .pack_viol (vliw_viol),
      .attr      (attr),
      .stat      (stat),
      .hit       (hit)
   );

   iax_first_pick #(.N(N_CHECKS)) u_pick (
      .hit (hit),
      .sel (sel)
   );

   iax_outcome u_outcome (
      .sel      (sel),
      .attr     (attr),
      .stat     (stat),
      .full_var (full_variant),
      .code     (code_c),
      .tt       (tt_c)
   );

   iax_out_stage #(.REGISTER_OUT(REGISTER_OUT), .SUB_W(SUB_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_in   (issue_vld),
      .code_in  (code_c),
      .tt_in    (tt_c),
      .vld_out  (res_vld),
      .code_out (code_q),
      .sub_out  (res_sub)
   );

   assign res_code = code_q;

endmodule

// File: rtl/insn_access_exc_check_sva.sv
`timescale 1ns/1ps
module insn_access_exc_check_sva #(
   parameter bit          REGISTER_OUT = 1'b1,
   parameter int unsigned SUB_W        = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue_vld,
   input logic             full_variant,
   input logic             vliw_viol,
   input logic             attr_float,
   input logic             attr_media,
   input logic             attr_mtrap,
   input logic             attr_fr_access,
   input logic             attr_nonexc,
   input logic             attr_cond,
   input logic             attr_priv,
   input logic             st_nonexc_en,
   input logic             st_cond_en,
   input logic             st_fp_en,
   input logic             st_media_en,
   input logic             st_super,
   input logic             res_vld,
   input logic [2:0]       res_code,
   input logic [SUB_W-1:0] res_sub
);

   logic [16:0] now_in;
   logic [16:0] cap;

   assign now_in = {issue_vld, full_variant, vliw_viol, attr_float, attr_media,
                    attr_mtrap, attr_fr_access, attr_nonexc, attr_cond, attr_priv,
                    st_nonexc_en, st_cond_en, st_fp_en, st_media_en, st_super,
                    2'b00};

   if (REGISTER_OUT) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cap <= '0;
         else        cap <= now_in;
      end
   end else begin : g_pass
      assign cap = now_in;
   end

   logic a_vld, a_full, a_viol, a_prv, a_sup, a_fpen, a_meden, a_nonimpl;
   assign a_vld     = cap[16];
   assign a_full    = cap[15];
   assign a_viol    = cap[14];
   assign a_prv     = cap[7];
   assign a_fpen    = cap[4];
   assign a_meden   = cap[3];
   assign a_sup     = cap[2];
   assign a_nonimpl = (cap[9] & ~cap[6]) | (cap[8] & ~cap[5]);

   AST_RESULT_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld == a_vld);  // R2
   AST_IDLE_IS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> (res_code == 3'd0 && res_sub == '0));  // R2
   AST_SUB_ONLY_FP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_code != 3'd2) |-> (res_sub == '0));  // R10
   AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_code != 3'd7);  // R8
   AST_REDUCED_NO_FP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !a_full) |-> (res_code != 3'd2 && res_code != 3'd3));  // R9
   AST_PACK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && a_viol) |->
      (res_code == 3'd1 || (res_code == 3'd2 && res_sub == SUB_W'(4))));  // R3
   AST_FP_OFF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !a_viol && !a_nonimpl && !a_fpen) |->
      (res_code == 3'd0 || res_code == 3'd4));  // R5
   AST_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !a_viol && !a_nonimpl && a_fpen && a_meden && a_prv && !a_sup)
      |-> res_code == 3'd6);  // R7

endmodule

bind insn_access_exc_check insn_access_exc_check_sva #(
   .REGISTER_OUT(REGISTER_OUT), .SUB_W(SUB_W)
) u_sva (.*);

// File: tb/insn_access_exc_check_tb_top.sv
`timescale 1ns/1ps
module insn_access_exc_check_tb_top;

   localparam real CLK_NS = 8.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_vld = 1'b0;
   logic [13:0] stim = '0;
   logic res_vld;
   logic [2:0] res_code;
   logic [2:0] res_sub;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_NS/2) clk = ~clk;

   // stim bits, MSB first: full viol flt med mtr fra nxc cnd prv nem cm ef em sup
   insn_access_exc_check dut_i (
      .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld),
      .full_variant(stim[13]), .vliw_viol(stim[12]),
      .attr_float(stim[11]), .attr_media(stim[10]), .attr_mtrap(stim[9]),
      .attr_fr_access(stim[8]), .attr_nonexc(stim[7]), .attr_cond(stim[6]),
      .attr_priv(stim[5]), .st_nonexc_en(stim[4]), .st_cond_en(stim[3]),
      .st_fp_en(stim[2]), .st_media_en(stim[1]), .st_super(stim[0]),
      .res_vld(res_vld), .res_code(res_code), .res_sub(res_sub)
   );

   typedef struct packed {
      logic [13:0] s;
      logic [2:0]  code;
      logic [2:0]  sub;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{14'b10000000011111, 3'd0, 3'd0, 4'd11}, // R11 plain instruction
      '{14'b11000000011111, 3'd1, 3'd0, 4'd3},  // R3 packing, integer
      '{14'b11100000011111, 3'd2, 3'd4, 4'd3},  // R3 packing, float
      '{14'b11010000011111, 3'd2, 3'd4, 4'd3},  // R3 packing, media
      '{14'b01100000011111, 3'd1, 3'd0, 4'd9},  // R9 reduced packing float
      '{14'b11000000111110, 3'd1, 3'd0, 4'd8},  // R8 packing beats privilege
      '{14'b10100010001111, 3'd2, 3'd3, 4'd4},  // R4 nonexc float
      '{14'b10010010001111, 3'd3, 3'd0, 4'd4},  // R4 nonexc media, R10 sub 0
      '{14'b10000001010111, 3'd1, 3'd0, 4'd4},  // R4 cond integer
      '{14'b00010001010111, 3'd1, 3'd0, 4'd9},  // R9 reduced cond media
      '{14'b10000011111110, 3'd6, 3'd0, 4'd7},  // R7 enabled forms, user priv
      '{14'b10100000011011, 3'd4, 3'd0, 4'd5},  // R5 fp off float
      '{14'b10000100011001, 3'd4, 3'd0, 4'd5},  // R5 fp off, fr access, media off
      '{14'b10000100011011, 3'd0, 3'd0, 4'd5},  // R5 fp off, fr access, media on
      '{14'b10000000111010, 3'd0, 3'd0, 4'd8},  // R8 fp off blocks privilege
      '{14'b10010000011001, 3'd0, 3'd0, 4'd8},  // R8 fp off blocks media off
      '{14'b10010000011101, 3'd5, 3'd0, 4'd6},  // R6 media off media
      '{14'b10001000011101, 3'd5, 3'd0, 4'd6},  // R6 media off media-trap
      '{14'b10000000111100, 3'd0, 3'd0, 4'd8},  // R8 media off blocks privilege
      '{14'b10000000111111, 3'd0, 3'd0, 4'd7},  // R7 supervisor priv
      '{14'b00100010001111, 3'd1, 3'd0, 4'd9},  // R9 reduced nonexc float
      '{14'b10110010001111, 3'd2, 3'd3, 4'd4},  // R4 float takes precedence over media
      '{14'b10100001010011, 3'd2, 3'd3, 4'd8},  // R8 cond beats fp off
      '{14'b00010010001111, 3'd1, 3'd0, 4'd9}   // R9 reduced nonexc media
   };

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_NS * 50000);
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 vld in reset", int'(res_vld), 0);
      chk("R1 code in reset", int'(res_code), 0);
      chk("R1 sub in reset", int'(res_sub), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 vld after reset", int'(res_vld), 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         stim = VECS[i].s;
         issue_vld = 1'b1;
         @(negedge clk);
         chk($sformatf("R%0d vec %0d vld", VECS[i].req, i), int'(res_vld), 1);
         chk($sformatf("R%0d vec %0d code", VECS[i].req, i), int'(res_code), int'(VECS[i].code));
         chk($sformatf("R%0d vec %0d sub", VECS[i].req, i), int'(res_sub), int'(VECS[i].sub));
         issue_vld = 1'b0;
      end

      // R2 idle with a faulting pattern present
      @(negedge clk);
      stim = 14'b11100000011111;
      issue_vld = 1'b0;
      @(negedge clk);
      chk("R2 idle vld", int'(res_vld), 0);
      chk("R2 idle code", int'(res_code), 0);
      chk("R2 idle sub", int'(res_sub), 0);

      // R2 one-cycle latency
      stim = 14'b11000000011111;
      issue_vld = 1'b1;
      #2;
      chk("R2 vld before edge", int'(res_vld), 0);
      @(negedge clk);
      chk("R2 vld after edge", int'(res_vld), 1);
      chk("R2 code after edge", int'(res_code), 1);

      // R1 reset mid-run clears the result
      rst_n = 1'b0;
      #1;
      chk("R1 vld on reset", int'(res_vld), 0);
      chk("R1 code on reset", int'(res_code), 0);
      issue_vld = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 vld after re-reset", int'(res_vld), 0);

      summary();
      $finish;
   end

endmodule